// File: doc/BRIEF.md
# Double-Buffered Pixel Plot Cache

This block sits between a graphics core's plot command and the frame RAM arbiter. Each accepted plot drops one pixel colour into an eight-slot row cache, the primary. A row is identified by its line number and its 8-pixel column. When the eighth slot fills, or a plot lands in a different row, the primary hands its contents to a secondary buffer in that same clock edge. The secondary then writes the row out to RAM as bitplane bytes while new plots keep filling the primary.

The flush sequencer issues one byte at a time. Each byte occupies the RAM port for a fixed number of cycles. A higher-priority CPU write request pauses the sequence between bytes, never inside one. Because of this, a later flush byte may overwrite a location the CPU stored in the gap. The core is told to stall only when a plot needs the primary to be emptied while the secondary is still occupied. The address is a linear placeholder: `{y, x[7:3], plane}`.

Top module: `pixel_plot_cache`

## Requirements
- R1: After synchronous active-low reset, `stall_o` and `ram_wr_o` are low, no flush is pending, and both caches are empty. The first flush after reset therefore contains only pixels plotted after reset.
- R2: An accepted, non-transparent plot stores its colour in slot `x[2:0]` of the row identified by `(y, x[7:3])`. A later plot to the same slot replaces the earlier colour.
- R3: The plot that fills the eighth slot hands the row to the secondary at the edge that accepts it. If the secondary was idle and `cpu_wr_req_i` is low, the first flush byte appears on `ram_wr_o` in the cycle after the next clock edge.
- R4: A flush writes 2 bytes when depth code 0 (2 bits per pixel) is in use, 4 bytes for code 1 (4 bits) and 8 bytes for code 2 or 3 (8 bits). The depth is the one in force when the row received its first pixel.
- R5: Flush byte p carries bit p of the colour of slot i in data bit 7-i, with 0 for empty slots. Its address is `{y, x[7:3], p[2:0]}`, and planes go out in ascending order.
- R6: Every flush byte keeps `ram_wr_o` high with stable address and data for exactly `BYTE_CYC` cycles. Bytes follow back to back when not paused.
- R7: No flush byte starts at a clock edge where `cpu_wr_req_i` is high. A byte already in progress completes, and the flush resumes once the request drops.
- R8: While the secondary drains, plots to the primary's row are accepted without stall as long as the primary is not full.
- R9: `stall_o` is high exactly when `plot_i` is high, the secondary is occupied, and either the primary is full or the plot is non-transparent and targets a different row than a non-empty primary. A stalled plot has no effect.
- R10: With `transp_en_i` high, a colour whose low bits for the current depth are all zero is not plotted: bits [1:0] for code 0 (so 0xFC is skipped), bits [3:0] for code 1, and all 8 bits otherwise. It neither changes the cache nor triggers a flush.
- R11: A non-transparent plot to a different row than a non-empty primary hands the partial row to the secondary, and the new pixel starts a fresh row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| plot_i | input | 1 | Plot request, held until not stalled |
| plot_x_i | input | X_W (8) | Pixel x coordinate |
| plot_y_i | input | Y_W (8) | Pixel y coordinate |
| plot_color_i | input | 8 | Pixel colour |
| depth_i | input | 2 | Colour depth code: 0 = 2 bpp, 1 = 4 bpp, 2/3 = 8 bpp |
| transp_en_i | input | 1 | Enable skipping of zero-valued colours |
| stall_o | output | 1 | Plot cannot be accepted this cycle |
| cpu_wr_req_i | input | 1 | Higher-priority CPU RAM write pending |
| ram_wr_o | output | 1 | Flush byte write active |
| ram_addr_o | output | X_W+Y_W (16) | Flush byte address |
| ram_data_o | output | 8 | Flush bitplane byte |

## Verification
Some properties are checked on every cycle:
- a stall only occurs while a plot is pending and the secondary is occupied;
- RAM activity only occurs while the secondary is occupied;
- each byte holds its address and data for its full length;
- no byte begins at an edge where the CPU requested the bus.

Other behaviours need the bench's scenarios and its cycle-level reference model: the exact bitplane contents, the byte count per depth, the skipping of transparent colours such as 0xFC, the early flush of a partial row, and the one-edge handoff on the eighth pixel. Those scenarios also show that plots paced three cycles apart at 2 bits per pixel never stall, while back-to-back 8-bit plots do.

// File: rtl/ppc_pkg.sv
// Package: shared constants and helper functions for the pixel plot cache.
// Assumes an 8-pixel row and colours of at most 8 bits.
package ppc_pkg;

    localparam int ROW_PIX = 8;

    localparam logic [1:0] DEPTH_2B = 2'd0;
    localparam logic [1:0] DEPTH_4B = 2'd1;
    localparam logic [1:0] DEPTH_8B = 2'd2;

    // Number of bitplane bytes a flush produces for a depth code.
    function automatic logic [3:0] plane_count(input logic [1:0] depth);
        case (depth)
            DEPTH_2B: return 4'd2;
            DEPTH_4B: return 4'd4;
            default:  return 4'd8;
        endcase
    endfunction

    // True when the colour's significant bits for the depth are all zero.
    function automatic logic is_clear(input logic [7:0] colour, input logic [1:0] depth);
        case (depth)
            DEPTH_2B: return colour[1:0] == 2'b00;
            DEPTH_4B: return colour[3:0] == 4'h0;
            default:  return colour == 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ppc_row_cache.sv
// Module: primary eight-slot row cache.
// Collects plotted pixels for one row (y, x/8) and decides when the row
// is handed to the secondary buffer: when the eighth slot fills (same
// edge) or when a plot targets a different row. Raises stall when a
// handoff is needed but the secondary is still occupied.
// Assumes X_W >= 4 and that depth is stable while a row is being filled.
module ppc_row_cache #(
    parameter int X_W = 8,
    parameter int Y_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  plot_i,
    input  logic [X_W-1:0]        x_i,
    input  logic [Y_W-1:0]        y_i,
    input  logic [7:0]            color_i,
    input  logic [1:0]            depth_i,
    input  logic                  transp_en_i,
    input  logic                  sec_busy_i,
    output logic                  stall_o,
    output logic                  move_o,
    output logic [7:0][7:0]       mv_color_o,
    output logic [7:0]            mv_valid_o,
    output logic [Y_W-1:0]        mv_y_o,
    output logic [X_W-4:0]        mv_blk_o,
    output logic [1:0]            mv_depth_o
);

    logic [7:0][7:0] col_q;
    logic [7:0]      val_q;
    logic [Y_W-1:0]  y_q;
    logic [X_W-4:0]  blk_q;
    logic [1:0]      dep_q;

    logic            any_pix, full, skip, mism, wr, move_old, move_new;
    logic [7:0]      slot_oh, val_mrg;
    logic [7:0][7:0] col_mrg;

    // Decide stall, write and handoff for the current cycle.
    always_comb begin
        any_pix  = |val_q;
        full     = &val_q;
        skip     = transp_en_i && ppc_pkg::is_clear(color_i, depth_i);
        mism     = any_pix && ((y_i != y_q) || (x_i[X_W-1:3] != blk_q));
        stall_o  = plot_i && sec_busy_i && (full || (!skip && mism));
        wr       = plot_i && !stall_o && !skip;
        move_old = !sec_busy_i && (full || (wr && mism));
        slot_oh  = 8'b1 << x_i[2:0];
        val_mrg  = (move_old ? 8'h00 : val_q) | (wr ? slot_oh : 8'h00);
        col_mrg  = col_q;
        if (wr) begin
            col_mrg[x_i[2:0]] = color_i;
        end
        move_new   = wr && !move_old && !sec_busy_i && (&val_mrg);
        move_o     = move_old || move_new;
        mv_color_o = move_old ? col_q : col_mrg;
        mv_valid_o = move_old ? val_q : val_mrg;
        mv_y_o     = y_q;
        mv_blk_o   = blk_q;
        mv_depth_o = dep_q;
    end

    // Update slots, valid bits and row tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            val_q <= '0;
            y_q   <= '0;
            blk_q <= '0;
            dep_q <= '0;
        end else begin
            val_q <= move_new ? 8'h00 : val_mrg;
            col_q <= col_mrg;
            if (wr && (!any_pix || move_old)) begin
                y_q   <= y_i;
                blk_q <= x_i[X_W-1:3];
                dep_q <= depth_i;
            end
        end
    end

endmodule

// File: rtl/ppc_flush_engine.sv
// Module: secondary buffer and bitplane flush sequencer.
// Takes a whole row from the primary in one edge and writes it out one
// bitplane byte at a time. Each byte holds the RAM port for BYTE_CYC
// cycles. A CPU write request blocks the start of the next byte only.
// Assumes move_i is asserted only while busy_o is low.
module ppc_flush_engine #(
    parameter int X_W      = 8,
    parameter int Y_W      = 8,
    parameter int BYTE_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               move_i,
    input  logic [7:0][7:0]    row_color_i,
    input  logic [7:0]         row_valid_i,
    input  logic [Y_W-1:0]     row_y_i,
    input  logic [X_W-4:0]     row_blk_i,
    input  logic [1:0]         row_depth_i,
    input  logic               cpu_wr_req_i,
    output logic               busy_o,
    output logic               ram_wr_o,
    output logic [X_W+Y_W-1:0] ram_addr_o,
    output logic [7:0]         ram_data_o
);

    localparam int CW = (BYTE_CYC > 1) ? $clog2(BYTE_CYC) : 1;

    logic                busy_q, act_q;
    logic [7:0][7:0]     col_q;
    logic [7:0]          val_q;
    logic [Y_W-1:0]      y_q;
    logic [X_W-4:0]      blk_q;
    logic [3:0]          nb_q;
    logic [2:0]          plane_q;
    logic [CW-1:0]       cnt_q;
    logic [X_W+Y_W-1:0]  addr_q;
    logic [7:0]          data_q;

    logic       ending, last, avail, start;
    logic [2:0] nxt_plane;
    logic [7:0] pbyte;

    // Byte boundary and start decisions.
    always_comb begin
        ending    = act_q && (cnt_q == CW'(BYTE_CYC - 1));
        last      = ({1'b0, plane_q} + 4'd1) == nb_q;
        avail     = busy_q && (!act_q || (ending && !last));
        start     = avail && !cpu_wr_req_i;
        nxt_plane = act_q ? plane_q + 3'd1 : plane_q;
    end

    // Build the bitplane byte: leftmost pixel in the most significant bit.
    for (genvar i = 0; i < ppc_pkg::ROW_PIX; i++) begin : g_pix
        assign pbyte[7-i] = val_q[i] & col_q[i][nxt_plane];
    end

    // Capture rows, sequence planes and time each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            act_q   <= 1'b0;
            col_q   <= '0;
            val_q   <= '0;
            y_q     <= '0;
            blk_q   <= '0;
            nb_q    <= '0;
            plane_q <= '0;
            cnt_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            if (move_i) begin
                busy_q  <= 1'b1;
                col_q   <= row_color_i;
                val_q   <= row_valid_i;
                y_q     <= row_y_i;
                blk_q   <= row_blk_i;
                nb_q    <= ppc_pkg::plane_count(row_depth_i);
                plane_q <= 3'd0;
            end
            if (start) begin
                act_q   <= 1'b1;
                cnt_q   <= '0;
                plane_q <= nxt_plane;
                addr_q  <= {y_q, blk_q, nxt_plane};
                data_q  <= pbyte;
            end else if (ending) begin
                act_q <= 1'b0;
                if (last) begin
                    busy_q <= 1'b0;
                end else begin
                    plane_q <= plane_q + 3'd1;
                end
            end else if (act_q) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign busy_o     = busy_q;
    assign ram_wr_o   = act_q;
    assign ram_addr_o = addr_q;
    assign ram_data_o = data_q;

endmodule

// File: rtl/pixel_plot_cache.sv
// Module: double-buffered pixel plot cache (top).
// Connects the primary row cache to the secondary flush engine and
// exposes the stall and RAM byte-write interface.
// Assumes the RAM arbiter accepts every flush byte it sees.
module pixel_plot_cache #(
    parameter int X_W      = 8,
    parameter int Y_W      = 8,
    parameter int BYTE_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               plot_i,
    input  logic [X_W-1:0]     plot_x_i,
    input  logic [Y_W-1:0]     plot_y_i,
    input  logic [7:0]         plot_color_i,
    input  logic [1:0]         depth_i,
    input  logic               transp_en_i,
    output logic               stall_o,
    input  logic               cpu_wr_req_i,
    output logic               ram_wr_o,
    output logic [X_W+Y_W-1:0] ram_addr_o,
    output logic [7:0]         ram_data_o
);

    logic            sec_busy, move;
    logic [7:0][7:0] mv_color;
    logic [7:0]      mv_valid;
    logic [Y_W-1:0]  mv_y;
    logic [X_W-4:0]  mv_blk;
    logic [1:0]      mv_depth;

    ppc_row_cache #(.X_W(X_W), .Y_W(Y_W)) u_row (
        .clk        (clk),
        .rst_n      (rst_n),
        .plot_i     (plot_i),
        .x_i        (plot_x_i),
        .y_i        (plot_y_i),
        .color_i    (plot_color_i),
        .depth_i    (depth_i),
        .transp_en_i(transp_en_i),
        .sec_busy_i (sec_busy),
        .stall_o    (stall_o),
        .move_o     (move),
        .mv_color_o (mv_color),
        .mv_valid_o (mv_valid),
        .mv_y_o     (mv_y),
        .mv_blk_o   (mv_blk),
        .mv_depth_o (mv_depth)
    );

    ppc_flush_engine #(.X_W(X_W), .Y_W(Y_W), .BYTE_CYC(BYTE_CYC)) u_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .move_i      (move),
        .row_color_i (mv_color),
        .row_valid_i (mv_valid),
        .row_y_i     (mv_y),
        .row_blk_i   (mv_blk),
        .row_depth_i (mv_depth),
        .cpu_wr_req_i(cpu_wr_req_i),
        .busy_o      (sec_busy),
        .ram_wr_o    (ram_wr_o),
        .ram_addr_o  (ram_addr_o),
        .ram_data_o  (ram_data_o)
    );

endmodule

// File: rtl/ppc_checker.sv
// Module: protocol checker for the pixel plot cache, bound to the top.
// Tracks the length of each flush byte with its own counter.
module ppc_checker #(
    parameter int BYTE_CYC = 3,
    parameter int AW       = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          plot_i,
    input logic          stall_o,
    input logic          cpu_wr_req_i,
    input logic          ram_wr_o,
    input logic [AW-1:0] ram_addr_o,
    input logic [7:0]    ram_data_o,
    input logic          sec_busy
);

    int   seen_q, seen;
    logic prev_wr_q, prev_cpu_q, byte_start;

    // Count the cycles the current flush byte has been shown.
    always_comb begin
        if (!ram_wr_o)                            seen = 0;
        else if (prev_wr_q && seen_q != BYTE_CYC) seen = seen_q + 1;
        else                                      seen = 1;
        byte_start = ram_wr_o && (seen == 1);
    end

    // Remember last cycle's byte count, write and CPU request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 0;
            prev_wr_q  <= 1'b0;
            prev_cpu_q <= 1'b0;
        end else begin
            seen_q     <= seen;
            prev_wr_q  <= ram_wr_o;
            prev_cpu_q <= cpu_wr_req_i;
        end
    end

    // R9: a stall needs a pending plot and an occupied secondary.
    p_stall_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (plot_i && sec_busy));

    // R6: RAM activity only while the secondary holds a row.
    p_wr_needs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_o |-> sec_busy);

    // R6: a byte keeps its address and data for its full length.
    p_byte_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr_o && seen < BYTE_CYC) |=>
        (ram_wr_o && $stable(ram_addr_o) && $stable(ram_data_o)));

    // R7: no byte begins at an edge where the CPU held the bus request.
    p_pause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_start |-> !prev_cpu_q);

endmodule

bind pixel_plot_cache ppc_checker #(.BYTE_CYC(BYTE_CYC), .AW(X_W + Y_W)) u_ppc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .plot_i      (plot_i),
    .stall_o     (stall_o),
    .cpu_wr_req_i(cpu_wr_req_i),
    .ram_wr_o    (ram_wr_o),
    .ram_addr_o  (ram_addr_o),
    .ram_data_o  (ram_data_o),
    .sec_busy    (sec_busy)
);

// File: tb/pixel_plot_cache_tb_top.sv
// Bench: behavioural reference model (queue of pending bytes) compared
// against the design every cycle, plus scenario checks per requirement.
module pixel_plot_cache_tb_top;

    localparam int BC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        plot = 1'b0;
    logic [7:0]  px = '0, py = '0, pc = '0;
    logic [1:0]  dep = '0;
    logic        ten = 1'b0, cpu = 1'b0;
    logic        stall, wr;
    logic [15:0] addr;
    logic [7:0]  data;

    int checks = 0, fails = 0;

    pixel_plot_cache #(.X_W(8), .Y_W(8), .BYTE_CYC(BC)) dut_i (
        .clk(clk), .rst_n(rst_n), .plot_i(plot), .plot_x_i(px), .plot_y_i(py),
        .plot_color_i(pc), .depth_i(dep), .transp_en_i(ten), .stall_o(stall),
        .cpu_wr_req_i(cpu), .ram_wr_o(wr), .ram_addr_o(addr), .ram_data_o(data)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] m_col [8];
    logic [7:0] m_val;
    logic [7:0] m_y;
    logic [4:0] m_blk;
    logic [1:0] m_dep;
    logic [23:0] q[$];
    int   cur_left;
    logic exp_wr;
    logic [15:0] exp_addr;
    logic [7:0]  exp_data;

    function automatic bit m_clear(logic [7:0] c, logic [1:0] d);
        if (d == 2'd0) return c[1:0] == 0;
        if (d == 2'd1) return c[3:0] == 0;
        return c == 0;
    endfunction

    function automatic int m_nb(logic [1:0] d);
        return (d == 2'd0) ? 2 : (d == 2'd1) ? 4 : 8;
    endfunction

    function automatic bit m_busy();
        return (cur_left > 0) || (q.size() > 0);
    endfunction

    function automatic bit m_mism();
        return (m_val != 0) && (py != m_y || px[7:3] != m_blk);
    endfunction

    function automatic bit m_stall();
        return plot && m_busy() && ((&m_val) || (!(ten && m_clear(pc, dep)) && m_mism()));
    endfunction

    task automatic push_row();
        for (int p = 0; p < m_nb(m_dep); p++) begin
            logic [7:0] b;
            for (int i = 0; i < 8; i++) b[7-i] = m_val[i] & m_col[i][p];
            q.push_back({m_y, m_blk, 3'(p), b});
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_val = '0; m_y = '0; m_blk = '0; m_dep = '0;
            for (int i = 0; i < 8; i++) m_col[i] = '0;
            q.delete(); cur_left = 0; exp_wr = 0; exp_addr = '0; exp_data = '0;
        end else begin
            bit busy, stl, w, mm;
            busy = m_busy();
            stl  = m_stall();
            mm   = m_mism();
            w    = plot && !stl && !(ten && m_clear(pc, dep));
            if (cur_left > 0) cur_left--;
            if (cur_left == 0 && q.size() > 0 && !cpu) begin
                logic [23:0] e;
                e = q.pop_front();
                cur_left = BC; exp_addr = e[23:8]; exp_data = e[7:0];
            end
            exp_wr = cur_left > 0;
            if (!busy && ((&m_val) || (w && mm))) begin
                push_row(); m_val = '0;
            end
            if (w) begin
                if (m_val == 0) begin m_y = py; m_blk = px[7:3]; m_dep = dep; end
                m_val[px[2:0]] = 1'b1;
                m_col[px[2:0]] = pc;
                if ((&m_val) && !busy) begin push_row(); m_val = '0; end
            end
        end
    end

    // ---------------- per-cycle comparison and byte counting ----------------
    int nbytes = 0, b_seen = 0, stall_cnt = 0;
    bit b_prev = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(stall == m_stall(), "R9", "stall_o", int'(stall), int'(m_stall()));
            chk(wr == exp_wr, "R6", "ram_wr_o", int'(wr), int'(exp_wr));
            if (exp_wr && wr) begin
                chk(addr == exp_addr, "R5", "ram_addr_o", int'(addr), int'(exp_addr));
                chk(data == exp_data, "R5", "ram_data_o", int'(data), int'(exp_data));
            end
            if (wr) begin
                if (!b_prev || b_seen == BC) begin nbytes++; b_seen = 1; end
                else b_seen++;
            end else b_seen = 0;
            b_prev = wr;
            if (stall) stall_cnt++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic plot_px(input int x, input int y, input int c, input int gap);
        @(posedge clk); #1;
        plot = 1'b1; px = 8'(x); py = 8'(y); pc = 8'(c);
        @(negedge clk);
        while (stall) @(negedge clk);
        @(posedge clk); #1;
        plot = 1'b0;
        repeat (gap) @(posedge clk);
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < BC + 4) begin
            @(negedge clk);
            quiet = wr ? 0 : quiet + 1;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk(stall == 0, "R1", "stall after reset", int'(stall), 0);
        chk(wr == 0, "R1", "ram_wr after reset", int'(wr), 0);

        // R2 R3 R4 R5: full 8bpp row, handoff on the eighth plot
        dep = 2'd2; ten = 0; nbytes = 0;
        for (int i = 0; i < 7; i++) plot_px(i, 3, i * 37 + 5, 1);
        plot_px(7, 3, 8'hA6, 0);
        @(negedge clk);
        chk(wr == 0, "R3", "no write one cycle after eighth plot", int'(wr), 0);
        @(negedge clk);
        chk(wr == 1, "R3", "write two cycles after eighth plot", int'(wr), 1);
        chk(addr == 16'h0300, "R3", "first flush address", int'(addr), 16'h0300);
        wait_idle();
        chk(nbytes == 8, "R4", "8bpp byte count", nbytes, 8);

        // R4: 4bpp row, includes overwrite of one slot (R2)
        dep = 2'd1; nbytes = 0;
        plot_px(9, 10, 8'h03, 1);
        for (int i = 8; i < 16; i++) plot_px(i, 10, i, 1);
        wait_idle();
        chk(nbytes == 4, "R4", "4bpp byte count", nbytes, 4);

        // R4 R8: 2bpp rows paced three cycles per plot never stall
        dep = 2'd0; nbytes = 0; stall_cnt = 0;
        for (int i = 0; i < 24; i++) plot_px(i, 12, i + 1, 1);
        wait_idle();
        chk(nbytes == 6, "R4", "2bpp byte count for three rows", nbytes, 6);
        chk(stall_cnt == 0, "R8", "stall cycles while secondary drains", stall_cnt, 0);

        // R10 R11: 0xFC is skipped in 2bpp transparent mode, then an early flush
        ten = 1; nbytes = 0;
        for (int i = 16; i < 23; i++) plot_px(i, 5, (i == 18) ? 8'hFC : i, 1);
        plot_px(23, 5, 8'hFC, 1);
        wait_idle();
        chk(nbytes == 0, "R10", "no flush after skipped eighth pixel", nbytes, 0);
        plot_px(40, 6, 8'h02, 1);
        wait_idle();
        chk(nbytes == 2, "R11", "partial row flushed on row change", nbytes, 2);
        dep = 2'd2; nbytes = 0;
        plot_px(41, 6, 8'h00, 1);
        wait_idle();
        chk(nbytes == 0, "R10", "8bpp zero colour skipped", nbytes, 0);
        ten = 0;

        // R9: back-to-back 8bpp plots fill both buffers and stall
        stall_cnt = 0; nbytes = 0;
        for (int i = 0; i < 24; i++) plot_px(i, 20, 8'hFF - i, 0);
        wait_idle();
        chk(stall_cnt > 0, "R9", "stall when both buffers occupied", stall_cnt, 1);
        chk(nbytes == 26, "R9", "byte count after stalled plots", nbytes, 26);

        // R7: CPU request from the eighth plot blocks the flush, then pauses mid-way
        nbytes = 0;
        for (int i = 0; i < 7; i++) plot_px(i + 48, 30, 8'h55 + i, 1);
        plot_px(55, 30, 8'h81, 0);
        cpu = 1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(wr == 0, "R7", "no byte while CPU holds the bus", int'(wr), 0);
        end
        @(posedge clk); #1 cpu = 0;
        @(negedge clk);
        while (!wr) @(negedge clk);
        @(posedge clk); #1 cpu = 1;
        repeat (8) @(posedge clk);
        #1 cpu = 0;
        wait_idle();
        chk(nbytes == 8, "R7", "paused flush resumes to completion", nbytes, 8);

        // R1: reset mid-row discards the pending pixels
        plot_px(0, 40, 8'h11, 1);
        @(posedge clk); #1 rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        nbytes = 0;
        for (int i = 0; i < 8; i++) plot_px(i + 8, 41, i + 1, 1);
        wait_idle();
        chk(nbytes == 8, "R1", "flush after reset holds only new row", nbytes, 8);

        summary();
        $finish;
    end

endmodule